// File: doc/BRIEF.md
# Single-Cycle Execute and Memory Datapath

This block is the back half of a single-cycle 32-bit processor: register read, arithmetic, data-memory access and register write-back. Each clock cycle it takes one instruction word from a fetch unit. It decodes the opcode and function fields and steers operands through one shared ALU. Any register-file or data-memory write happens on the next rising clock edge.

Three bits go back to the fetch unit: Zero, meaning the ALU result is zero; a branch request; and a jump request. The fetch unit uses them to pick the next program counter. The instruction set is register add and subtract, OR with an immediate, word load, word store, branch-if-equal and jump.

Immediates are zero-extended for the OR instruction and sign-extended for load, store and branch. The data memory is small, internal and addressed by word. Its address wraps modulo its depth.

Top module: `dp_exec_core`

## Requirements
- R1: Opcode 0 with function 32 (bits [5:0]) writes R[rs] + R[rt] (modulo 2^32) into register rd. rs is bits [25:21], rt is [20:16] and rd is [15:11].
- R2: Opcode 0 with function 34 writes R[rs] - R[rt] (modulo 2^32) into rd.
- R3: Opcode 0x0D writes R[rs] OR {16'b0, imm} into rt. The immediate is bits [15:0].
- R4: Opcode 0x23 loads the data word at index (R[rs] + sign-extended imm) bits [5:2] into rt, with the default depth of 16 words. The address wraps modulo the depth.
- R5: Opcode 0x2B stores R[rt] into the word at the same index as R4, and it changes no register.
- R6: Opcode 0x04 raises branch_o. Zero is high exactly when R[rs] equals R[rt]. Nothing is written.
- R7: Opcode 0x02 raises jump_o with branch_o low. Nothing is written.
- R8: Register 0 always reads as zero, and writes to it are discarded.
- R9: For the six data instructions, zero_o is high exactly when the ALU result (the sum, difference, OR, or address) is zero. branch_o and jump_o are low for every opcode other than 0x04 and 0x02.
- R10: A synchronous active-low reset clears every register and every data-memory word to zero.
- R11: Undefined opcodes, and opcode 0 with a function other than 32 or 34, write neither the register file nor the data memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| instr | input | 32 | Instruction word for the current cycle |
| zero_o | output | 1 | ALU result equals zero |
| branch_o | output | 1 | Branch-if-equal decoded |
| jump_o | output | 1 | Jump decoded |

## Verification
The only outputs are Zero, branch and jump, so the bench reads state back through instructions. It rebuilds each expected register value in a scratch register using OR-immediate and doubling adds, then compares the two with branch-if-equal. A bad write, a wrong destination field or a lost store therefore shows up as a wrong Zero bit.

The corner cases the bench goes after are these:
- A negative load or store offset. A zero-extending design would address the wrong word.
- An OR immediate with bit 15 set. A sign-extending design would set the upper half of the result.
- Writes to register 0. A design that stores them would later read back non-zero.
- Addresses past the top of memory. A design that does not wrap them would address the wrong word.

Sweeps over every undefined function code and every undefined opcode then look for any stray register or memory write.

// File: rtl/dp_pkg.sv
// Shared encodings and the control word for the execute datapath.
// Assumes the fixed 32-bit instruction layout with opcode in [31:26].
package dp_pkg;
    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_ORI   = 6'h0D;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_JMP   = 6'h02;
    localparam logic [5:0] FN_ADD   = 6'd32;
    localparam logic [5:0] FN_SUB   = 6'd34;

    typedef enum logic [1:0] {
        ALU_ADD = 2'd0,
        ALU_SUB = 2'd1,
        ALU_OR  = 2'd2
    } alu_op_e;

    typedef struct packed {
        logic    rf_we;
        logic    dst_rd;
        logic    src_imm;
        logic    sign_ext;
        logic    mem_we;
        logic    mem_to_reg;
        logic    branch;
        logic    jump;
        alu_op_e alu_op;
    } ctrl_t;
endpackage

// File: rtl/dp_decode.sv
// Control decoder: maps opcode and function fields to a control word.
// Assumes undefined codes must leave all write enables low.
module dp_decode
    import dp_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);
    // Derive one control word per instruction class.
    always_comb begin
        ctrl = '0;
        ctrl.alu_op = ALU_ADD;
        case (opcode)
            OP_RTYPE: begin
                ctrl.dst_rd = 1'b1;
                if (funct == FN_ADD) begin
                    ctrl.rf_we  = 1'b1;
                    ctrl.alu_op = ALU_ADD;
                end else if (funct == FN_SUB) begin
                    ctrl.rf_we  = 1'b1;
                    ctrl.alu_op = ALU_SUB;
                end
            end
            OP_ORI: begin
                ctrl.rf_we   = 1'b1;
                ctrl.src_imm = 1'b1;
                ctrl.alu_op  = ALU_OR;
            end
            OP_LW: begin
                ctrl.rf_we      = 1'b1;
                ctrl.src_imm    = 1'b1;
                ctrl.sign_ext   = 1'b1;
                ctrl.mem_to_reg = 1'b1;
            end
            OP_SW: begin
                ctrl.src_imm  = 1'b1;
                ctrl.sign_ext = 1'b1;
                ctrl.mem_we   = 1'b1;
            end
            OP_BEQ: begin
                ctrl.sign_ext = 1'b1;
                ctrl.branch   = 1'b1;
                ctrl.alu_op   = ALU_SUB;
            end
            OP_JMP: begin
                ctrl.jump = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dp_regfile.sv
// Register file: two combinational read ports, one clocked write port.
// Assumes entry 0 is hard-wired to zero; it is never stored.
module dp_regfile #(
    parameter int DW = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b
);
    localparam int NREG = 1 << AW;

    logic [DW-1:0] regs [NREG];

    // Clear on reset, otherwise commit one write to a non-zero entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    // Read both ports, forcing entry 0 to zero.
    always_comb begin
        rd_a = (ra_a == '0) ? '0 : regs[ra_a];
        rd_b = (ra_b == '0) ? '0 : regs[ra_b];
    end
endmodule

// File: rtl/dp_alu.sv
// Shared ALU: add, subtract, OR, with a zero-result flag.
// Assumes wrap-around arithmetic with no overflow trap.
module dp_alu
    import dp_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  alu_op_e       op,
    output logic [DW-1:0] y,
    output logic          zero
);
    // Select the operation result.
    always_comb begin
        case (op)
            ALU_SUB: y = a - b;
            ALU_OR:  y = a | b;
            default: y = a + b;
        endcase
    end

    // Flag an all-zero result.
    always_comb zero = (y == '0);
endmodule

// File: rtl/dp_dmem.sv
// Data memory: word array indexed by byte address bits above [1:0].
// Assumes DEPTH is a power of two; higher address bits wrap.
module dp_dmem #(
    parameter int DW    = 32,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int IW = $clog2(DEPTH);

    logic [DW-1:0] words [DEPTH];
    logic [IW-1:0] idx;
    logic          unused_addr_bits;

    // Pick the word index out of the byte address.
    always_comb idx = addr[IW+1:2];
    always_comb unused_addr_bits = ^{addr[1:0], addr[DW-1:IW+2]};

    // Clear on reset, otherwise store one word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) words[i] <= '0;
        end else if (we) begin
            words[idx] <= wdata;
        end
    end

    // Combinational read.
    always_comb rdata = words[idx];
endmodule

// File: rtl/dp_exec_core.sv
// Single-cycle execute/memory/write-back datapath.
// Assumes a fetch unit supplies one instruction per cycle and consumes
// zero_o, branch_o and jump_o to form the next program counter.
module dp_exec_core
    import dp_pkg::*;
#(
    parameter int DW        = 32,
    parameter int RF_AW     = 5,
    parameter int MEM_DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] instr,
    output logic        zero_o,
    output logic        branch_o,
    output logic        jump_o
);
    localparam int IMM_W = 16;

    ctrl_t            ctrl;
    logic [5:0]       opcode, funct;
    logic [RF_AW-1:0] ra_a, ra_b, wa;
    logic [IMM_W-1:0] imm;
    logic [DW-1:0]    bus_a, bus_b, ext_imm, alu_b, alu_y, mem_rdata, wb_data;
    logic             rf_we, mem_we, mem_to_reg;
    logic             unused_instr_bits;

    // Slice the instruction fields.
    always_comb begin
        opcode = instr[31:26];
        funct  = instr[5:0];
        ra_a   = instr[21 +: RF_AW];
        ra_b   = instr[16 +: RF_AW];
        imm    = instr[15:0];
        unused_instr_bits = ^instr[10:6];
    end

    dp_decode u_dec (
        .opcode (opcode),
        .funct  (funct),
        .ctrl   (ctrl)
    );

    // Route control bits and pick the destination register.
    always_comb begin
        rf_we      = ctrl.rf_we;
        mem_we     = ctrl.mem_we;
        mem_to_reg = ctrl.mem_to_reg;
        wa         = ctrl.dst_rd ? instr[11 +: RF_AW] : ra_b;
    end

    dp_regfile #(.DW(DW), .AW(RF_AW)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra_a  (ra_a),
        .ra_b  (ra_b),
        .we    (rf_we),
        .wa    (wa),
        .wd    (wb_data),
        .rd_a  (bus_a),
        .rd_b  (bus_b)
    );

    // Extend the immediate and choose the second ALU operand.
    always_comb begin
        ext_imm = ctrl.sign_ext ? {{(DW-IMM_W){imm[IMM_W-1]}}, imm}
                                : {{(DW-IMM_W){1'b0}}, imm};
        alu_b   = ctrl.src_imm ? ext_imm : bus_b;
    end

    dp_alu #(.DW(DW)) u_alu (
        .a    (bus_a),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (zero_o)
    );

    dp_dmem #(.DW(DW), .DEPTH(MEM_DEPTH)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .addr  (alu_y),
        .wdata (bus_b),
        .rdata (mem_rdata)
    );

    // Choose write-back data and drive fetch-side control.
    always_comb begin
        wb_data  = mem_to_reg ? mem_rdata : alu_y;
        branch_o = ctrl.branch;
        jump_o   = ctrl.jump;
    end
endmodule

// File: rtl/dp_exec_chk.sv
// Checker for dp_exec_core, attached by bind below.
// Assumes it samples only after reset has been released.
module dp_exec_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          branch_o,
    input logic          jump_o,
    input logic          rf_we,
    input logic          mem_we,
    input logic          mem_to_reg,
    input logic [4:0]    ra_a,
    input logic [DW-1:0] bus_a
);
    AST_BR_JMP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(branch_o && jump_o)); // R7
    AST_BEQ_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        branch_o |-> (!rf_we && !mem_we)); // R6
    AST_JUMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        jump_o |-> (!rf_we && !mem_we)); // R7
    AST_STORE_NO_RF: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !rf_we); // R5
    AST_LOAD_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        mem_to_reg |-> (rf_we && !mem_we)); // R4
    AST_R0_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_a == 5'd0) |-> (bus_a == '0)); // R8
endmodule

bind dp_exec_core dp_exec_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .branch_o   (branch_o),
    .jump_o     (jump_o),
    .rf_we      (rf_we),
    .mem_we     (mem_we),
    .mem_to_reg (mem_to_reg),
    .ra_a       (ra_a),
    .bus_a      (bus_a)
);

// File: tb/sim_dp_exec_core.sv
// Bench: drives instruction sequences and predicts Zero/branch/jump from
// an arithmetic model of registers and memory; state is read back through
// branch-if-equal against a value rebuilt in scratch register 31.
module sim_dp_exec_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = 32'h0;
    logic        zero_o, branch_o, jump_o;

    int vecs = 0;
    int errs = 0;
    bit done = 1'b0;

    logic [31:0] m_rf  [32];
    logic [31:0] m_mem [16];

    always #5 clk = ~clk;

    dp_exec_core u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .instr    (instr),
        .zero_o   (zero_o),
        .branch_o (branch_o),
        .jump_o   (jump_o)
    );

    function automatic logic [31:0] mk_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] mk_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 32; i++) m_rf[i] = '0;
        for (int i = 0; i < 16; i++) m_mem[i] = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        instr = 32'h0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_clear();
    endtask

    // Apply one instruction, compare the outputs, then advance the model.
    task automatic exec(input logic [31:0] ins, input string tag);
        logic [5:0]  op, fn;
        int          rs, rt, rd, wreg;
        logic [31:0] a, b, ze, se, res, wval;
        bit          zk, wr, mw;
        logic [2:0]  exp_v, act_v, mask;
        op = ins[31:26]; fn = ins[5:0];
        rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
        a = m_rf[rs]; b = m_rf[rt];
        ze = {16'h0, ins[15:0]};
        se = {{16{ins[15]}}, ins[15:0]};
        zk = 1'b1; wr = 1'b0; mw = 1'b0; wreg = 0; res = '0; wval = '0;
        case (op)
            6'h00: begin
                if (fn == 6'd32) begin res = a + b; wr = 1'b1; wreg = rd; wval = res; end
                else if (fn == 6'd34) begin res = a - b; wr = 1'b1; wreg = rd; wval = res; end
                else zk = 1'b0;
            end
            6'h0D: begin res = a | ze; wr = 1'b1; wreg = rt; wval = res; end
            6'h23: begin res = a + se; wr = 1'b1; wreg = rt; wval = m_mem[res[5:2]]; end
            6'h2B: begin res = a + se; mw = 1'b1; end
            6'h04: res = a - b;
            default: zk = 1'b0;
        endcase
        exp_v = {op == 6'h04, op == 6'h02, res == '0};
        mask  = {2'b11, zk};
        @(negedge clk);
        instr = ins;
        #4;
        act_v = {branch_o, jump_o, zero_o};
        vecs++;
        if ((act_v & mask) != (exp_v & mask)) begin
            errs++;
            $display("FAIL %s instr=%h {branch,jump,zero} actual=%b expected=%b",
                     tag, ins, act_v, exp_v);
        end
        @(posedge clk);
        #1;
        if (wr && wreg != 0) m_rf[wreg] = wval;
        if (mw) m_mem[res[5:2]] = b;
    endtask

    // Rebuild the expected value of register r in r31 and compare with beq.
    task automatic check_reg(input int r, input string tag);
        logic [31:0] e;
        e = m_rf[r];
        exec(mk_i(6'h0D, 0, 31, e[31:16]), tag);
        for (int k = 0; k < 16; k++) exec(mk_r(31, 31, 31, 6'd32), tag);
        exec(mk_i(6'h0D, 31, 31, e[15:0]), tag);
        exec(mk_i(6'h04, r, 31, 16'h0), tag);
    endtask

    // Load word i into r30 and compare it.
    task automatic check_mem(input int i, input string tag);
        exec(mk_i(6'h23, 0, 30, 16'(i * 4)), tag);
        check_reg(30, tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            vecs++;
            errs++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        model_clear();
        do_reset();

        // R10: reset state of every register and memory word.
        for (int r = 1; r < 31; r++) check_reg(r, "R10");
        for (int i = 0; i < 16; i++) check_mem(i, "R10");

        // R3: OR-immediate with bit 15 set, zero extension.
        for (int r = 1; r < 30; r++) begin
            exec(mk_i(6'h0D, 0, r, 16'((r * 16'h0911) ^ 16'h8001)), "R3");
            check_reg(r, "R3");
        end
        exec(mk_i(6'h0D, 5, 5, 16'hF0F0), "R3");
        check_reg(5, "R3");

        // R1 / R2: add and subtract over several operand pairs.
        for (int k = 0; k < 8; k++) begin
            exec(mk_r(k + 1, k + 3, 20 + k, 6'd32), "R1");
            check_reg(20 + k, "R1");
            exec(mk_r(k + 2, k + 7, 12 + k, 6'd34), "R2");
            check_reg(12 + k, "R2");
        end
        exec(mk_r(3, 3, 7, 6'd34), "R2");    // zero difference
        check_reg(7, "R2");
        for (int k = 0; k < 20; k++) exec(mk_r(8, 8, 8, 6'd32), "R1");  // wraps
        check_reg(8, "R1");
        exec(mk_r(0, 9, 10, 6'd34), "R2");   // negative result
        check_reg(10, "R2");

        // R8: register 0 stays zero.
        exec(mk_i(6'h0D, 0, 0, 16'hFFFF), "R8");
        exec(mk_r(1, 2, 0, 6'd32), "R8");
        check_reg(0, "R8");
        exec(mk_r(0, 0, 11, 6'd32), "R8");
        check_reg(11, "R8");

        // R5 / R4: store to every word, read back, negative offsets, wrap.
        for (int i = 0; i < 16; i++) begin
            exec(mk_i(6'h2B, 0, i + 1, 16'(i * 4)), "R5");
            check_mem(i, "R5");
            check_reg(i + 1, "R5");
        end
        exec(mk_i(6'h0D, 0, 9, 16'd64), "R4");
        exec(mk_i(6'h2B, 9, 24, 16'hFFFC), "R5");   // address 60
        check_mem(15, "R5");
        exec(mk_i(6'h23, 9, 10, 16'hFFF8), "R4");   // address 56
        check_reg(10, "R4");
        exec(mk_i(6'h23, 9, 11, 16'h0004), "R4");   // address 68 wraps to word 1
        check_reg(11, "R4");
        exec(mk_i(6'h2B, 9, 25, 16'h0000), "R5");   // address 64 wraps to word 0
        check_mem(0, "R5");

        // R6: branch-if-equal, equal and unequal, no writes.
        exec(mk_i(6'h04, 4, 4, 16'h0008), "R6");
        exec(mk_i(6'h04, 4, 6, 16'hFFFF), "R6");
        check_reg(6, "R6");
        check_mem(3, "R6");

        // R7: jump raises only jump and writes nothing.
        exec({6'h02, 5'd1, 5'd12, 16'h0014}, "R7");
        check_reg(12, "R7");
        check_mem(5, "R7");

        // R9: Zero tracks the ALU result for each instruction class.
        exec(mk_r(0, 0, 13, 6'd32), "R9");
        exec(mk_i(6'h0D, 0, 13, 16'h0000), "R9");
        exec(mk_i(6'h23, 9, 14, 16'hFFC0), "R9");   // address exactly zero

        // R11: undefined function codes write nothing.
        for (int f = 0; f < 64; f++) begin
            if (f != 32 && f != 34) begin
                exec(mk_r(1, 2, 13, 6'(f)), "R11");
                check_reg(13, "R11");
            end
        end
        // R11: undefined opcodes write nothing.
        for (int o = 1; o < 64; o++) begin
            if (o != 6'h0D && o != 6'h23 && o != 6'h2B && o != 6'h04 && o != 6'h02) begin
                exec(mk_i(6'(o), 0, 14, 16'h0004), "R11");
                check_reg(14, "R11");
                check_mem(1, "R11");
            end
        end

        // R10: reset after activity clears everything again.
        do_reset();
        for (int r = 1; r < 31; r++) check_reg(r, "R10");
        for (int i = 0; i < 16; i++) check_mem(i, "R10");

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule